// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM that keeps its bus busy on every clock. Address, control and the byte-lane write mask are registered on each enabled rising edge. Write data follows its address by two enabled cycles, which is the same distance as read data. Reads and writes can therefore be mixed in any order, and the bus never needs a dead cycle when it turns from reading to writing or back.

A cycle either loads a new address or advances a four-beat burst from the last loaded address. The burst walks either linearly or in an interleaved (XOR) order. Three chip enables select the device. A hold input freezes the entire pipeline and memory. Data in and data out are separate buses, and a valid flag stands in for an output enable.

Top module: `zt_sram`

## Requirements
- R1: A read whose address is registered at enabled edge n drives `rdata_o` with the addressed word, and `rvalid_o` high, after enabled edge n+2.
- R2: A write whose address is registered at enabled edge n takes `wdata_i` at enabled edge n+2, and `rvalid_o` is low after that edge.
- R3: Reads and writes may be issued on consecutive enabled cycles in any mix, with no idle cycle between them.
- R4: During a write, only the lanes whose `lane_wr_i` bit is 1 (bit k covers `wdata_i[k*LANE_W +: LANE_W]`) are updated. The other lanes keep their contents.
- R5: With `order_i`=0 at the load, each cycle with `adv_i`=1 after the load addresses the loaded address with its two low bits replaced by (low bits + beat count) mod 4, where the beat count runs 1, 2, 3, 0, ...
- R6: With `order_i`=1 at the load, the two low bits of each burst beat are the loaded low bits XOR the beat count.
- R7: A load cycle (`adv_i`=0) is a deselect unless `ce0_n_i`=0, `ce1_i`=1 and `ce2_n_i`=0. A deselect writes nothing, and `rvalid_o` is low two enabled cycles later.
- R8: While `hold_i`=1, every other input is ignored. Outputs, pipeline and memory keep their values.
- R9: A read issued the cycle after a write to the same address returns the newly written lanes, merged lane by lane with the stored lanes.
- R10: After reset, `rvalid_o` is 0 and no operation is in flight.
- R11: A cycle with `adv_i`=1 keeps the read/write direction of the last load and ignores `rnw_i`. After a deselect load, it stays a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | 1 suspends the whole block |
| adv_i | input | 1 | 0 loads an address, 1 advances the burst |
| rnw_i | input | 1 | At a load: 1 read, 0 write |
| ce0_n_i | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_n_i | input | 1 | Chip enable, active low |
| order_i | input | 1 | At a load: 0 linear, 1 interleaved burst |
| lane_wr_i | input | LANES | Per-lane write mask for the cycle's address |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, two enabled cycles after its address |
| rdata_o | output | LANES*LANE_W | Read data |
| rvalid_o | output | 1 | `rdata_o` holds read data |

## Verification
The assertions assume that the control inputs are known at every sampled edge after reset. They also assume that the pipeline distance counts only edges with `hold_i` low, so each latency property requires hold to be low on the two following edges. The stimulus drives every input to a defined value at each falling edge. It fills the whole memory before the first read, so each read returns defined data. Hold cycles are placed inside bursts and between an address and its data, and the bench model counts only enabled edges.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              adv_i,
  input  logic              rnw_i,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              ce2_n_i,
  input  logic              order_i,
  input  logic [LANES-1:0]  lane_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              rvalid_o
);

  logic [W-1:0] mem [DEPTH];

  logic              bact, bwr, bord;
  logic [ADDR_W-1:0] bbase;
  logic [1:0]        bcnt;

  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_m, s2_m;
  logic [W-1:0]      rd_q;

  wire       sel    = !ce0_n_i && ce1_i && !ce2_n_i;
  wire [1:0] cnt_nx = bcnt + 2'd1;
  wire [1:0] low    = bord ? (bbase[1:0] ^ cnt_nx) : (bbase[1:0] + cnt_nx);

  wire              iss_v  = adv_i ? bact : sel;
  wire              iss_wr = adv_i ? bwr  : !rnw_i;
  wire [ADDR_W-1:0] iss_a  = adv_i ? {bbase[ADDR_W-1:2], low} : addr_i;

  wire          hit     = s2_v && s2_wr && (s2_a == s1_a);
  wire [W-1:0]  rd_word = mem[s1_a];
  logic [W-1:0] fwd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fwd[g*LANE_W +: LANE_W] = (hit && s2_m[g]) ? wdata_i[g*LANE_W +: LANE_W]
                                                      : rd_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bact <= 1'b0; bwr <= 1'b0; bord <= 1'b0; bbase <= '0; bcnt <= '0;
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_a <= '0; s1_m <= '0;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_a <= '0; s2_m <= '0;
      rd_q <= '0; rdata_o <= '0; rvalid_o <= 1'b0;
    end else if (!hold_i) begin
      if (!adv_i) begin
        bact  <= sel;
        bwr   <= !rnw_i;
        bord  <= order_i;
        bbase <= addr_i;
        bcnt  <= '0;
      end else begin
        bcnt  <= cnt_nx;
      end
      s1_v  <= iss_v;
      s1_wr <= iss_wr;
      s1_a  <= iss_a;
      s1_m  <= lane_wr_i;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_m  <= s1_m;
      rd_q  <= fwd;
      rvalid_o <= s2_v && !s2_wr;
      if (s2_v && !s2_wr) rdata_o <= rd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold_i && s2_v && s2_wr) begin
      for (int l = 0; l < LANES; l++) begin
        if (s2_m[l]) mem[s2_a][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hold_i,
  input logic         adv_i,
  input logic         rnw_i,
  input logic         ce0_n_i,
  input logic         ce1_i,
  input logic         ce2_n_i,
  input logic [W-1:0] rdata_o,
  input logic         rvalid_o
);

  wire sel = !ce0_n_i && ce1_i && !ce2_n_i;

  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(rvalid_o) && $stable(rdata_o)));

  assert_desel_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !adv_i && !sel) ##1 !hold_i ##1 !hold_i |=> !rvalid_o);

  assert_write_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !adv_i && sel && !rnw_i) ##1 !hold_i ##1 !hold_i |=> !rvalid_o);

  assert_read_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !adv_i && sel && rnw_i) ##1 !hold_i ##1 !hold_i |=> rvalid_o);

endmodule

bind zt_sram zt_sram_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .adv_i(adv_i), .rnw_i(rnw_i),
  .ce0_n_i(ce0_n_i), .ce1_i(ce1_i), .ce2_n_i(ce2_n_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int AW = 4, LN = 2, LW = 9, W = LN*LW, D = 1 << AW;
  localparam logic [2:0] SEL = 3'b010;

  logic clk = 0, rst_n = 0;
  logic hold_i = 0, adv_i = 0, rnw_i = 1, ce0_n_i = 1, ce1_i = 0, ce2_n_i = 1, order_i = 0;
  logic [LN-1:0] lane_wr_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [W-1:0]  wdata_i = '0, rdata_o;
  logic          rvalid_o;

  always #4 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .adv_i(adv_i), .rnw_i(rnw_i),
    .ce0_n_i(ce0_n_i), .ce1_i(ce1_i), .ce2_n_i(ce2_n_i), .order_i(order_i),
    .lane_wr_i(lane_wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o));

  int total = 0, bad = 0;
  string req = "R10";
  logic ord = 0;

  logic [W-1:0]  mem_m [D];
  logic          m_act = 0, m_wr = 0, m_ord = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          p_v [2] = '{0, 0};
  logic          p_wr [2] = '{0, 0};
  logic [AW-1:0] p_a [2];
  logic [LN-1:0] p_m [2];
  logic          exp_v = 0;
  logic [W-1:0]  exp_d = '0;

  task automatic chk(input logic ok, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic adv, input logic rnw, input logic [2:0] ce,
                      input logic hold, input logic [AW-1:0] a, input logic [LN-1:0] m);
    logic [W-1:0] wd;
    logic nv, nw;
    logic [AW-1:0] na;
    logic [1:0] c;
    wd = W'($urandom);
    hold_i = hold; adv_i = adv; rnw_i = rnw; order_i = ord;
    {ce2_n_i, ce1_i, ce0_n_i} = ce;
    addr_i = a; lane_wr_i = m; wdata_i = wd;
    @(posedge clk); @(negedge clk);
    if (!hold) begin
      if (p_v[1] && p_wr[1])
        for (int l = 0; l < LN; l++)
          if (p_m[1][l]) mem_m[p_a[1]][l*LW +: LW] = wd[l*LW +: LW];
      exp_v = p_v[1] && !p_wr[1];
      if (exp_v) exp_d = mem_m[p_a[1]];
      if (!adv) begin
        m_act = (ce == SEL); m_wr = !rnw; m_ord = ord; m_base = a; m_cnt = 0;
        nv = m_act; nw = m_wr; na = a;
      end else begin
        m_cnt = m_cnt + 2'd1;
        c = m_ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        nv = m_act; nw = m_wr; na = {m_base[AW-1:2], c};
      end
      p_v[1] = p_v[0]; p_wr[1] = p_wr[0]; p_a[1] = p_a[0]; p_m[1] = p_m[0];
      p_v[0] = nv; p_wr[0] = nw; p_a[0] = na; p_m[0] = m;
    end
    chk(rvalid_o === exp_v && (!exp_v || rdata_o === exp_d),
        {rvalid_o, rdata_o}, {exp_v, exp_d});
  endtask

  task automatic ld(input logic rnw, input logic [AW-1:0] a, input logic [LN-1:0] m);
    step(1'b0, rnw, SEL, 1'b0, a, m);
  endtask
  task automatic cont(input logic rnw, input logic [LN-1:0] m);
    step(1'b1, rnw, SEL, 1'b0, '0, m);
  endtask
  task automatic idle();
    step(1'b0, 1'b1, 3'b111, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    req = "R10";
    chk(rvalid_o === 1'b0, {rvalid_o, rdata_o}, '0);
    idle(); idle();
  endtask

  task automatic t_fill();
    req = "R5_R11_fill"; ord = 0;
    for (int b = 0; b < D/4; b++) begin
      ld(1'b0, AW'(b*4), '1);
      cont(1'b1, '1); cont(1'b0, '1); cont(1'b1, '1);
    end
    idle(); idle();
  endtask

  task automatic t_linear();
    req = "R5_R1"; ord = 0;
    ld(1'b1, 4'd6, '0); cont(1'b0, '1); cont(1'b1, '0); cont(1'b0, '1);
    ld(1'b1, 4'd3, '0); cont(1'b1, '0);
    idle(); idle();
  endtask

  task automatic t_inter();
    req = "R6"; ord = 1;
    ld(1'b1, 4'd9, '0); cont(1'b1, '0); cont(1'b1, '0); cont(1'b1, '0);
    ld(1'b0, 4'd14, '1); cont(1'b1, '1); cont(1'b1, '1); cont(1'b1, '1);
    ld(1'b1, 4'd14, '0); cont(1'b1, '0); cont(1'b1, '0); cont(1'b1, '0);
    idle(); idle();
    ord = 0;
  endtask

  task automatic t_alt();
    req = "R3_R9";
    ld(1'b0, 4'd3, '1); ld(1'b1, 4'd3, '0); ld(1'b0, 4'd5, '1); ld(1'b1, 4'd5, '0);
    ld(1'b1, 4'd3, '0); ld(1'b0, 4'd3, '1); ld(1'b1, 4'd3, '0); ld(1'b0, 4'd4, '1);
    idle(); idle();
  endtask

  task automatic t_bytes();
    req = "R4_R9";
    ld(1'b0, 4'd2, 2'b01); ld(1'b1, 4'd2, '0);
    ld(1'b0, 4'd2, 2'b10); ld(1'b1, 4'd2, '0);
    ld(1'b0, 4'd2, 2'b00); ld(1'b1, 4'd2, '0);
    idle(); idle();
    req = "R4"; ld(1'b1, 4'd2, '0); idle(); idle();
  endtask

  task automatic t_desel();
    req = "R7";
    step(1'b0, 1'b0, 3'b011, 1'b0, 4'd1, '1);
    step(1'b0, 1'b0, 3'b000, 1'b0, 4'd1, '1);
    step(1'b0, 1'b0, 3'b110, 1'b0, 4'd1, '1);
    req = "R11";
    cont(1'b0, '1); cont(1'b0, '1);
    req = "R7"; ld(1'b1, 4'd1, '0); idle(); idle();
  endtask

  task automatic t_hold();
    req = "R8";
    ld(1'b1, 4'd7, '0);
    step(1'b0, 1'b0, SEL, 1'b1, 4'd7, '1);
    step(1'b1, 1'b0, SEL, 1'b1, 4'd7, '1);
    cont(1'b1, '0);
    step(1'b0, 1'b0, SEL, 1'b1, 4'd8, '1);
    idle(); idle();
    ld(1'b0, 4'd12, '1); cont(1'b0, '1);
    step(1'b0, 1'b1, SEL, 1'b1, 4'd0, '0);
    step(1'b0, 1'b1, SEL, 1'b1, 4'd0, '0);
    cont(1'b1, '1); cont(1'b1, '1);
    ld(1'b1, 4'd12, '0); cont(1'b0, '0); cont(1'b0, '0); cont(1'b0, '0);
    idle(); idle();
  endtask

  initial begin
    for (int i = 0; i < D; i++) mem_m[i] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    t_linear();
    t_inter();
    t_alt();
    t_bytes();
    t_desel();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule